// File: doc/BRIEF.md
# Core Module System Control Register Block

This block is a word-addressed register file that a processor uses to identify the board, tune its clock words, configure memory and ask for a system reset. The host drives a single-cycle request (`req_valid`, `req_write`, byte address, write data). Reads return their data on a registered output one clock later.

Two clock words can only be changed after the host writes a 16-bit unlock key into the lock register. The control word drives an LED level and a memory-remap level. Its reset bit is never stored; writing it produces a one-cycle reset request pulse. Two flag registers are each changed through a pair of addresses, one that sets bits and one that clears them.

The memory configuration word takes its reset value from the `MEM_MB` size parameter. A read-only byte window at byte offsets 0x100 to 0x1FF returns presence-detect bytes from a constant table. The table's last entry also follows `MEM_MB`. A read of an address with no register returns zero and sets a sticky error flag.

Top module: `sysctl_regs`

## Requirements
- R1: A read of word 0 returns 0x411A3001, a read of word 4 returns 0x00100000, and a read of word 1 returns zero. Writes to these words change nothing.
- R2: A write to word 5 stores bits [15:0] of the data. A read of word 5 returns 0x0001A05F while the stored value is 0xA05F, and otherwise returns the stored value zero-extended.
- R3: Words 2 and 7 reset to 0x01000048 and 0x0007FEFF. A write to either word takes effect only while word 5 holds 0xA05F; at any other time the write is dropped.
- R4: A write to word 3 with data bit 3 set makes `sys_reset_req` high for exactly one cycle, starting at the clock edge that accepts the write. Bit 3 always reads back as zero.
- R5: Word 3 stores only data bits 0 and 2; all other bits read as zero. `led_on` equals stored bit 0 and `ram_at_zero` equals stored bit 2. Both reset to 0.
- R6: A write to word 12 ORs the data into the flag register and a write to word 13 clears the bits set in the data. A read of word 12 returns the flags, which reset to 0.
- R7: Words 14 and 15 set and clear a second flag register in the same way. A read of word 14 returns it, and it resets to 0.
- R8: A read at byte offset 0x100 + 4*i, for i from 0 to 31, returns entry i of the presence-detect table in bits [7:0] with zeros above. Entry 0 is 128 and entry 7 is 0. Byte offsets 0x180 to 0x1FF read zero, and writes into the window are ignored.
- R9: Word 8 resets to 0x00011122 ORed with a size code. The code is 0x10 for `MEM_MB` of 256 or more, 0x0C for 128 or more, 0x08 for 64 or more, 0x04 for 32 or more, and 0 below that. Table entry 31 is 64, 32, 16, 4 or 2 to match. Word 8 is freely writable.
- R10: Word 9 resets to 0x00000112 and is freely writable. Words 32 to 35 read zero and ignore writes.
- R11: A read of any other word (for example 6, 10, 13, 15 or 16 to 31) returns zero and sets `bad_access`. Once set, `bad_access` stays high until reset.
- R12: `rd_data` changes only at the clock edge that accepts a read and holds its value through writes and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (9) | Byte address; bits [1:0] are ignored |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| sys_reset_req | output | 1 | One-cycle system reset request |
| led_on | output | 1 | LED level, control bit 0 |
| ram_at_zero | output | 1 | Remap level, control bit 2 |
| bad_access | output | 1 | Sticky unimplemented-read flag |

## Verification
Every result becomes visible one clock after the edge that accepts the access. Read data, the reset pulse, the LED and remap levels, register updates and the error flag all follow this rule. The bench drives each request on a falling edge and samples on the next falling edge, which is after exactly one rising edge. Register effects are checked by a read that follows the write, or directly at the output pins. The reset pulse is sampled in two places: on the falling edge after the accepting edge, where it must be high, and one cycle later, where it must be low again.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam logic [31:0] ID_VALUE   = 32'h411A_3001;
  localparam logic [31:0] STAT_VALUE = 32'h0010_0000;
  localparam logic [31:0] OSC_RST    = 32'h0100_0048;
  localparam logic [31:0] AUX_RST    = 32'h0007_FEFF;
  localparam logic [31:0] SDRAM_BASE = 32'h0001_1122;
  localparam logic [31:0] INIT_RST   = 32'h0000_0112;
  localparam logic [15:0] UNLOCK_KEY = 16'hA05F;

  // word indices inside the register region
  localparam int W_ID     = 0;
  localparam int W_PROC   = 1;
  localparam int W_OSC    = 2;
  localparam int W_CTRL   = 3;
  localparam int W_STAT   = 4;
  localparam int W_LOCK   = 5;
  localparam int W_AUX    = 7;
  localparam int W_SDRAM  = 8;
  localparam int W_INIT   = 9;
  localparam int W_FLG_S  = 12;
  localparam int W_FLG_C  = 13;
  localparam int W_NVF_S  = 14;
  localparam int W_NVF_C  = 15;
  localparam int W_VOLT0  = 32;
  localparam int W_VOLT3  = 35;

  // control word bit positions
  localparam int CB_LED   = 0;
  localparam int CB_REMAP = 2;
  localparam int CB_RESET = 3;

  function automatic logic [7:0] size_code(input int mb);
    if (mb >= 256)      return 8'h10;
    else if (mb >= 128) return 8'h0C;
    else if (mb >= 64)  return 8'h08;
    else if (mb >= 32)  return 8'h04;
    else                return 8'h00;
  endfunction

  function automatic logic [7:0] spd_rows(input int mb);
    if (mb >= 256)      return 8'd64;
    else if (mb >= 128) return 8'd32;
    else if (mb >= 64)  return 8'd16;
    else if (mb >= 32)  return 8'd4;
    else                return 8'd2;
  endfunction
endpackage

// File: rtl/sysctl_spd_rom.sv
module sysctl_spd_rom #(
  parameter int MEM_MB = 128,
  parameter int IDX_W  = 5
) (
  input  logic [IDX_W-1:0] idx,
  output logic [7:0]       byte_out
);
  import sysctl_pkg::*;

  localparam logic [7:0] SIZE_ENTRY = spd_rows(MEM_MB);

  always_comb begin
    case (idx)
      IDX_W'(0):  byte_out = 8'd128;
      IDX_W'(1):  byte_out = 8'd8;
      IDX_W'(2):  byte_out = 8'd4;
      IDX_W'(3):  byte_out = 8'd11;
      IDX_W'(4):  byte_out = 8'd9;
      IDX_W'(5):  byte_out = 8'd1;
      IDX_W'(6):  byte_out = 8'd64;
      IDX_W'(8):  byte_out = 8'd2;
      IDX_W'(9):  byte_out = 8'hA0;
      IDX_W'(10): byte_out = 8'hA0;
      IDX_W'(13): byte_out = 8'd8;
      IDX_W'(15): byte_out = 8'd1;
      IDX_W'(16): byte_out = 8'h0E;
      IDX_W'(17): byte_out = 8'd4;
      IDX_W'(18): byte_out = 8'h1C;
      IDX_W'(19): byte_out = 8'd1;
      IDX_W'(20): byte_out = 8'd2;
      IDX_W'(21): byte_out = 8'h20;
      IDX_W'(22): byte_out = 8'hC0;
      IDX_W'(27): byte_out = 8'h30;
      IDX_W'(28): byte_out = 8'h28;
      IDX_W'(29): byte_out = 8'h30;
      IDX_W'(30): byte_out = 8'h28;
      IDX_W'(31): byte_out = SIZE_ENTRY;
      default:    byte_out = 8'h00;
    endcase
  end
endmodule

// File: rtl/sysctl_setclr.sv
module sysctl_setclr #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] bits_in,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;
  logic         q_en;

  always_comb begin
    q_en = set_en | clr_en;
    q_d  = q;
    if (set_en) q_d = q | bits_in;
    if (clr_en) q_d = q & ~bits_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_d;
  end
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs #(
  parameter int ADDR_W = 9,
  parameter int MEM_MB = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic [31:0]       rd_data,
  output logic              sys_reset_req,
  output logic              led_on,
  output logic              ram_at_zero,
  output logic              bad_access
);
  import sysctl_pkg::*;

  localparam int WORD_W  = ADDR_W - 2;
  localparam int WIN_BIT = 8;
  localparam int ROM_W   = WIN_BIT - 3;
  localparam logic [31:0] SDRAM_RST = SDRAM_BASE | {24'b0, size_code(MEM_MB)};

  logic [WORD_W-1:0] word_idx;
  logic              in_window;
  logic              wr_reg, rd_any;
  logic [7:0]        spd_byte;

  logic [31:0] osc_q, aux_q, sdram_q, init_q, rdata_q;
  logic [15:0] lock_q;
  logic        led_q, remap_q, rst_req_q, err_q;
  logic [31:0] flags_q, nvflags_q;

  logic [31:0] osc_d, aux_d, sdram_d, init_d, rdata_d;
  logic [15:0] lock_d;
  logic        led_d, remap_d, rst_req_d, err_d;
  logic        osc_en, aux_en, sdram_en, init_en, lock_en, ctrl_en, rdata_en;
  logic        key_ok;
  logic [31:0] rd_val;
  logic        rd_bad;

  assign word_idx  = req_addr[ADDR_W-1:2];
  assign in_window = req_addr[WIN_BIT];
  assign wr_reg    = req_valid & req_write & ~in_window;
  assign rd_any    = req_valid & ~req_write;
  assign key_ok    = (lock_q == UNLOCK_KEY);

  sysctl_spd_rom #(.MEM_MB(MEM_MB), .IDX_W(ROM_W)) u_rom (
    .idx      (req_addr[WIN_BIT-2:2]),
    .byte_out (spd_byte)
  );

  sysctl_setclr #(.W(32)) u_flags (
    .clk (clk), .rst_n (rst_n),
    .set_en  (wr_reg && word_idx == WORD_W'(W_FLG_S)),
    .clr_en  (wr_reg && word_idx == WORD_W'(W_FLG_C)),
    .bits_in (req_wdata), .q (flags_q)
  );

  sysctl_setclr #(.W(32)) u_nvflags (
    .clk (clk), .rst_n (rst_n),
    .set_en  (wr_reg && word_idx == WORD_W'(W_NVF_S)),
    .clr_en  (wr_reg && word_idx == WORD_W'(W_NVF_C)),
    .bits_in (req_wdata), .q (nvflags_q)
  );

  // write-side next state
  always_comb begin
    osc_en   = wr_reg && word_idx == WORD_W'(W_OSC) && key_ok;
    aux_en   = wr_reg && word_idx == WORD_W'(W_AUX) && key_ok;
    lock_en  = wr_reg && word_idx == WORD_W'(W_LOCK);
    ctrl_en  = wr_reg && word_idx == WORD_W'(W_CTRL);
    sdram_en = wr_reg && word_idx == WORD_W'(W_SDRAM);
    init_en  = wr_reg && word_idx == WORD_W'(W_INIT);
    osc_d    = req_wdata;
    aux_d    = req_wdata;
    lock_d   = req_wdata[15:0];
    sdram_d  = req_wdata;
    init_d   = req_wdata;
    led_d    = req_wdata[CB_LED];
    remap_d  = req_wdata[CB_REMAP];
    rst_req_d = ctrl_en & req_wdata[CB_RESET];
  end

  // read-side decode
  always_comb begin
    rd_val = '0;
    rd_bad = 1'b0;
    if (in_window) begin
      if (!req_addr[WIN_BIT-1]) rd_val = {24'b0, spd_byte};
    end else begin
      case (word_idx)
        WORD_W'(W_ID):    rd_val = ID_VALUE;
        WORD_W'(W_PROC):  rd_val = '0;
        WORD_W'(W_OSC):   rd_val = osc_q;
        WORD_W'(W_CTRL):  rd_val = {29'b0, remap_q, 1'b0, led_q};
        WORD_W'(W_STAT):  rd_val = STAT_VALUE;
        WORD_W'(W_LOCK):  rd_val = {15'b0, key_ok, lock_q};
        WORD_W'(W_AUX):   rd_val = aux_q;
        WORD_W'(W_SDRAM): rd_val = sdram_q;
        WORD_W'(W_INIT):  rd_val = init_q;
        WORD_W'(W_FLG_S): rd_val = flags_q;
        WORD_W'(W_NVF_S): rd_val = nvflags_q;
        WORD_W'(W_VOLT0), WORD_W'(W_VOLT0+1),
        WORD_W'(W_VOLT0+2), WORD_W'(W_VOLT3): rd_val = '0;
        default:          rd_bad = 1'b1;
      endcase
    end
    rdata_en = rd_any;
    rdata_d  = rd_val;
    err_d    = err_q | (rd_any & rd_bad);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osc_q     <= OSC_RST;
      aux_q     <= AUX_RST;
      lock_q    <= '0;
      sdram_q   <= SDRAM_RST;
      init_q    <= INIT_RST;
      led_q     <= 1'b0;
      remap_q   <= 1'b0;
      rst_req_q <= 1'b0;
      err_q     <= 1'b0;
      rdata_q   <= '0;
    end else begin
      if (osc_en)   osc_q   <= osc_d;
      if (aux_en)   aux_q   <= aux_d;
      if (lock_en)  lock_q  <= lock_d;
      if (sdram_en) sdram_q <= sdram_d;
      if (init_en)  init_q  <= init_d;
      if (ctrl_en) begin
        led_q   <= led_d;
        remap_q <= remap_d;
      end
      rst_req_q <= rst_req_d;
      err_q     <= err_d;
      if (rdata_en) rdata_q <= rdata_d;
    end
  end

  assign rd_data       = rdata_q;
  assign sys_reset_req = rst_req_q;
  assign led_on        = led_q;
  assign ram_at_zero   = remap_q;
  assign bad_access    = err_q;
endmodule

// File: rtl/sysctl_regs_chk.sv
module sysctl_regs_chk #(
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [31:0]       req_wdata,
  input logic [31:0]       rd_data,
  input logic              sys_reset_req,
  input logic              led_on,
  input logic              ram_at_zero,
  input logic              bad_access,
  input logic [15:0]       lock_q,
  input logic [31:0]       osc_q
);
  logic wr_ctrl, wr_osc, rd_lock;
  assign wr_ctrl = req_valid && req_write && req_addr == ADDR_W'(12);
  assign wr_osc  = req_valid && req_write && req_addr == ADDR_W'(8);
  assign rd_lock = req_valid && !req_write && req_addr == ADDR_W'(20);

  a_r4_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset_req |=> !sys_reset_req);

  a_r4_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && req_wdata[3]) |=> sys_reset_req);

  a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_ctrl && req_wdata[3]) |=> !sys_reset_req);

  a_r3_osc_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_osc && lock_q != 16'hA05F) |=> $stable(osc_q));

  a_r5_levels_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> ($stable(led_on) && $stable(ram_at_zero)));

  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    bad_access |=> bad_access);

  a_r12_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> $stable(rd_data));

  a_r2_key_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lock && lock_q == 16'hA05F) |=> rd_data == 32'h0001_A05F);
endmodule

bind sysctl_regs sysctl_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_write (req_write),
  .req_addr (req_addr), .req_wdata (req_wdata), .rd_data (rd_data),
  .sys_reset_req (sys_reset_req), .led_on (led_on), .ram_at_zero (ram_at_zero),
  .bad_access (bad_access), .lock_q (lock_q), .osc_q (osc_q)
);

// File: tb/sysctl_regs_test.sv
module sysctl_regs_test;
  localparam int ADDR_W = 9;
  localparam int MEM_MB = 128;

  logic              clk;
  logic              rst_n;
  logic              req_valid, req_write;
  logic [ADDR_W-1:0] req_addr;
  logic [31:0]       req_wdata;
  logic [31:0]       rd_data;
  logic              sys_reset_req, led_on, ram_at_zero, bad_access;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  sysctl_regs #(.ADDR_W(ADDR_W), .MEM_MB(MEM_MB)) uut (
    .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_write (req_write),
    .req_addr (req_addr), .req_wdata (req_wdata), .rd_data (rd_data),
    .sys_reset_req (sys_reset_req), .led_on (led_on),
    .ram_at_zero (ram_at_zero), .bad_access (bad_access)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [31:0] exp_sdram(input int mb);
    logic [31:0] c;
    c = (mb >= 256) ? 32'h10 : (mb >= 128) ? 32'h0C : (mb >= 64) ? 32'h08 :
        (mb >= 32) ? 32'h04 : 32'h0;
    return 32'h0001_1122 | c;
  endfunction

  function automatic logic [31:0] exp_entry31(input int mb);
    return (mb >= 256) ? 32'd64 : (mb >= 128) ? 32'd32 : (mb >= 64) ? 32'd16 :
           (mb >= 32) ? 32'd4 : 32'd2;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic bus_write(input int byte_addr, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1;
    req_addr = ADDR_W'(byte_addr); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_read(input int byte_addr, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = ADDR_W'(byte_addr);
    @(negedge clk);
    req_valid = 1'b0;
    d = rd_data;
  endtask

  task automatic t_reset_state();
    logic [31:0] v;
    check("R5 led reset", 32'(led_on), 0);
    check("R5 remap reset", 32'(ram_at_zero), 0);
    check("R4 reset_req idle", 32'(sys_reset_req), 0);
    check("R11 err reset", 32'(bad_access), 0);
    bus_read(0, v);      check("R1 id", v, 32'h411A_3001);
    bus_read(4, v);      check("R1 proc", v, 0);
    bus_read(16, v);     check("R1 status", v, 32'h0010_0000);
    bus_read(8, v);      check("R3 osc reset", v, 32'h0100_0048);
    bus_read(28, v);     check("R3 aux reset", v, 32'h0007_FEFF);
    bus_read(32, v);     check("R9 sdram reset", v, exp_sdram(MEM_MB));
    bus_read(36, v);     check("R10 init reset", v, 32'h112);
    bus_read(12, v);     check("R5 ctrl reset", v, 0);
    bus_read(20, v);     check("R2 lock reset", v, 0);
    bus_read(48, v);     check("R6 flags reset", v, 0);
    bus_read(56, v);     check("R7 nvflags reset", v, 0);
    bus_write(0, 32'h0); bus_write(16, 32'hFFFF_FFFF);
    bus_read(0, v);      check("R1 id after write", v, 32'h411A_3001);
    bus_read(16, v);     check("R1 status after write", v, 32'h0010_0000);
  endtask

  task automatic t_lock_and_osc();
    logic [31:0] v;
    bus_write(8, 32'h1234_5678);
    bus_read(8, v);  check("R3 osc write while locked", v, 32'h0100_0048);
    bus_write(20, 32'hBEEF_A05E);
    bus_read(20, v); check("R2 wrong key readback", v, 32'h0000_A05E);
    bus_write(28, 32'h5555_0000);
    bus_read(28, v); check("R3 aux write wrong key", v, 32'h0007_FEFF);
    bus_write(20, 32'hFFFF_A05F);
    bus_read(20, v); check("R2 key readback", v, 32'h0001_A05F);
    bus_write(8, 32'h1234_5678);
    bus_read(8, v);  check("R3 osc write unlocked", v, 32'h1234_5678);
    bus_write(28, 32'h0000_00AA);
    bus_read(28, v); check("R3 aux write unlocked", v, 32'h0000_00AA);
    bus_write(20, 32'h0);
    bus_write(8, 32'hDEAD_0000);
    bus_read(8, v);  check("R3 osc relocked", v, 32'h1234_5678);
  endtask

  task automatic t_control();
    logic [31:0] v;
    bus_write(12, 32'hFFFF_FFF7);
    check("R5 led level", 32'(led_on), 1);
    check("R5 remap level", 32'(ram_at_zero), 1);
    check("R4 no pulse without bit3", 32'(sys_reset_req), 0);
    bus_read(12, v); check("R5 ctrl readback", v, 32'h5);
    bus_write(12, 32'h4);
    check("R5 led cleared", 32'(led_on), 0);
    check("R5 remap kept", 32'(ram_at_zero), 1);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = ADDR_W'(12); req_wdata = 32'h9;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    check("R4 pulse high", 32'(sys_reset_req), 1);
    @(negedge clk);
    check("R4 pulse one cycle", 32'(sys_reset_req), 0);
    bus_read(12, v); check("R4 bit3 reads zero", v, 32'h1);
  endtask

  task automatic t_flags();
    logic [31:0] v;
    bus_write(48, 32'h0000_00F0);
    bus_write(48, 32'h8000_0001);
    bus_read(48, v); check("R6 flags set", v, 32'h8000_00F1);
    bus_write(52, 32'h0000_0031);
    bus_read(48, v); check("R6 flags clear", v, 32'h8000_00C0);
    bus_write(56, 32'h0000_FF00);
    bus_write(60, 32'h0000_0F00);
    bus_read(56, v); check("R7 nvflags", v, 32'h0000_F000);
    bus_read(48, v); check("R7 flags untouched", v, 32'h8000_00C0);
  endtask

  task automatic t_window();
    logic [31:0] v;
    bus_read(32'h100, v); check("R8 entry0", v, 128);
    bus_read(32'h11C, v); check("R8 entry7", v, 0);
    bus_read(32'h124, v); check("R8 entry9", v, 32'hA0);
    bus_read(32'h17C, v); check("R9 entry31", v, exp_entry31(MEM_MB));
    bus_read(32'h180, v); check("R8 upper half zero", v, 0);
    bus_read(32'h1FC, v); check("R8 top zero", v, 0);
    bus_write(32'h100, 32'h0);
    bus_read(32'h100, v); check("R8 write ignored", v, 128);
  endtask

  task automatic t_misc_words();
    logic [31:0] v;
    bus_write(32, 32'hCAFE_0001);
    bus_read(32, v);  check("R9 sdram write", v, 32'hCAFE_0001);
    bus_write(36, 32'h0000_0777);
    bus_read(36, v);  check("R10 init write", v, 32'h0000_0777);
    bus_write(128, 32'hFFFF_FFFF);
    bus_read(128, v); check("R10 volt0", v, 0);
    bus_read(140, v); check("R10 volt3", v, 0);
    check("R11 no err yet", 32'(bad_access), 0);
  endtask

  task automatic t_bad_and_hold();
    logic [31:0] v;
    bus_read(0, v);
    bus_write(32, 32'h1);
    check("R12 rdata held over write", rd_data, 32'h411A_3001);
    @(negedge clk);
    check("R12 rdata held idle", rd_data, 32'h411A_3001);
    bus_read(24, v);  check("R11 bad read data", v, 0);
    check("R11 err set", 32'(bad_access), 1);
    bus_read(0, v);
    check("R11 err sticky", 32'(bad_access), 1);
    bus_read(64, v);  check("R11 word16 zero", v, 0);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_lock_and_osc();
    t_control();
    t_flags();
    t_window();
    t_misc_words();
    t_bad_and_hold();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule